// File: doc/BRIEF.md
# Tuner Synthesizer Divider and Phase Detector Core

This block is the digital half of a TV tuner's frequency synthesizer. It runs on one fast system clock. Two single-cycle enable inputs tell it when an edge arrives from the prescaled VCO and when one arrives from the crystal. A 15-bit programmable divider counts the VCO events. A reference divider counts the crystal events with one of three fixed ratios. A phase/frequency detector compares the two divided event streams and produces up/down steering pulses for an external charge pump.

A lock detector measures how long each steering pulse lasts. It raises a lock flag after a run of clean comparisons and drops the flag when a pulse grows too wide. For production test, a registered output can carry a divide-by-two copy of either the reference event stream or the main divider event stream.

New divider words and new reference ratios take effect only when the running count reaches its terminal value. A change made mid-count therefore never produces a shortened output period.

Top module: `tpll_core`

## Requirements
- R1: The main divider emits one output event for every N VCO tick events, where N is the 15-bit word `div_word`. Words 0 and 1 act as 2. The first VCO tick after reset produces an event at once.
- R2: A new `div_word` is taken only at the main divider's terminal count. After a change, the period that is in progress completes with the old word, and the following period uses the new one.
- R3: The reference divider ratio follows `ref_sel`: 2'b00 gives 64, 2'b01 gives 80, 2'b10 gives 128, and the reserved code 2'b11 also gives 128. A change takes effect only at the reference terminal count, in the same way as R2.
- R4: `pd_up` is set by a reference event and `pd_dn` by a divider event. When the reference leads, only `pd_up` is high alone; when the divider leads, only `pd_dn` is high alone.
- R5: When `pd_up` and `pd_dn` are both high, both go low on the next clock. They are never both high for two cycles in a row.
- R6: A comparison is clean when the time one steering output is high alone is shorter than `WIN_CYC` clocks. `lock` rises on the clock after the eighth consecutive clean comparison (`LOCK_CNT`).
- R7: `lock` falls, and the run of clean comparisons restarts from zero, as soon as a steering pulse is high alone for `WIN_CYC` clocks.
- R8: With `test_en` high, `test_out` toggles once per reference event when `test_sel` is 0, and once per divider event when `test_sel` is 1. Its half-period therefore equals the selected ratio in ticks.
- R9: With `test_en` low, `test_out` is 0.
- R10: During and right after reset, `pd_up`, `pd_dn`, `lock` and `test_out` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| vco_tick | input | 1 | One-cycle event from the prescaled VCO |
| xtal_tick | input | 1 | One-cycle event from the crystal clock |
| div_word | input | 15 | Main division ratio |
| ref_sel | input | 2 | Reference ratio code |
| test_en | input | 1 | Enables the test output |
| test_sel | input | 1 | Test source: 0 reference, 1 main divider |
| pd_up | output | 1 | Steering pulse: raise VCO frequency |
| pd_dn | output | 1 | Steering pulse: lower VCO frequency |
| lock | output | 1 | Loop lock flag |
| test_out | output | 1 | Half-rate test signal |

## Verification
The bench uses the default parameters: a 15-bit divider word, a lock window `WIN_CYC` of 4 clocks and a lock run `LOCK_CNT` of 8. Both tick inputs are held high so that every clock is an event. Divider and reference periods can then be read directly in clocks through the test output, including the reserved ratio code and the clamped words. The small window lets fixed phase offsets of 0, 3 and 4 clocks sit exactly on both sides of the lock boundary. A one-count mismatch (65 or 63 against a ratio of 64) lets the error grow through the window within a few comparisons, which exercises the loss of lock and both steering directions.

// File: rtl/tpll_pkg.sv
package tpll_pkg;

  localparam int REF_W = 8;

  typedef enum logic [1:0] {
    REF_64  = 2'b00,
    REF_80  = 2'b01,
    REF_128 = 2'b10,
    REF_RSV = 2'b11
  } ref_sel_e;

  // Reference ratio for a select code; the reserved code maps to the slowest ratio.
  function automatic logic [REF_W-1:0] ref_ratio(input logic [1:0] sel);
    case (ref_sel_e'(sel))
      REF_64:  ref_ratio = REF_W'(64);
      REF_80:  ref_ratio = REF_W'(80);
      default: ref_ratio = REF_W'(128);
    endcase
  endfunction

  // Effective main ratio: values below two are raised to two.
  function automatic logic [14:0] eff_ratio(input logic [14:0] word);
    eff_ratio = (word < 15'd2) ? 15'd2 : word;
  endfunction

endpackage

// File: rtl/tc_divider.sv
// Terminal-count divider: reloads only when the count expires.
module tc_divider #(
  parameter int CW = 15
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic [CW-1:0] load_val,
  output logic          pulse,
  output logic          half
);

  logic [CW-1:0] cnt;
  logic          term;

  assign term = (cnt <= CW'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt   <= '0;
      pulse <= 1'b0;
      half  <= 1'b0;
    end else begin
      pulse <= tick && term;
      if (tick) begin
        if (term) cnt <= load_val;
        else      cnt <= cnt - CW'(1);
      end
      if (pulse) half <= ~half;
    end
  end

endmodule

// File: rtl/tpll_pfd.sv
// Phase/frequency detector with a single-cycle coincident reset.
module tpll_pfd (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_ev,
  input  logic div_ev,
  output logic up,
  output logic dn,
  output logic clr_evt
);

  assign clr_evt = up && dn;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      up <= 1'b0;
      dn <= 1'b0;
    end else if (clr_evt) begin
      up <= 1'b0;
      dn <= 1'b0;
    end else begin
      if (ref_ev) up <= 1'b1;
      if (div_ev) dn <= 1'b1;
    end
  end

endmodule

// File: rtl/tpll_lockdet.sv
// Lock detector: counts clean comparisons, drops on a wide error pulse.
module tpll_lockdet #(
  parameter int WIN_CYC  = 4,
  parameter int LOCK_CNT = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic up,
  input  logic dn,
  input  logic cmp_done,
  output logic lock,
  output logic wide_err
);

  localparam int WW = $clog2(WIN_CYC + 1);
  localparam int GW = $clog2(LOCK_CNT + 1);
  localparam logic [WW-1:0] WIN_V  = WW'(WIN_CYC);
  localparam logic [WW-1:0] WIN_M1 = WW'(WIN_CYC - 1);
  localparam logic [GW-1:0] RUN_V  = GW'(LOCK_CNT);
  localparam logic [GW-1:0] RUN_M1 = GW'(LOCK_CNT - 1);

  logic [WW-1:0] wcnt;
  logic [GW-1:0] gcnt;
  logic          alone;

  assign alone    = up ^ dn;
  assign wide_err = alone && (wcnt >= WIN_M1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wcnt <= '0;
      gcnt <= '0;
      lock <= 1'b0;
    end else if (cmp_done) begin
      wcnt <= '0;
      if (wcnt < WIN_V) begin
        if (gcnt == RUN_M1) lock <= 1'b1;
        if (gcnt != RUN_V)  gcnt <= gcnt + GW'(1);
      end else begin
        gcnt <= '0;
        lock <= 1'b0;
      end
    end else if (alone) begin
      if (wcnt != WIN_V) wcnt <= wcnt + WW'(1);
      if (wide_err) begin
        gcnt <= '0;
        lock <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/tpll_core.sv
module tpll_core #(
  parameter int DIV_W    = 15,
  parameter int WIN_CYC  = 4,
  parameter int LOCK_CNT = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             vco_tick,
  input  logic             xtal_tick,
  input  logic [DIV_W-1:0] div_word,
  input  logic [1:0]       ref_sel,
  input  logic             test_en,
  input  logic             test_sel,
  output logic             pd_up,
  output logic             pd_dn,
  output logic             lock,
  output logic             test_out
);
  import tpll_pkg::*;

  // Named internal events for the checker.
  logic ref_pulse, div_pulse, ref_half, div_half;
  logic cmp_done, wide_err;
  logic [DIV_W-1:0] div_load;

  generate
    if (DIV_W == 15) begin : g_std
      assign div_load = eff_ratio(div_word);
    end else begin : g_gen
      assign div_load = (div_word < DIV_W'(2)) ? DIV_W'(2) : div_word;
    end
  endgenerate

  tc_divider #(.CW(DIV_W)) u_main (
    .clk(clk), .rst_n(rst_n), .tick(vco_tick), .load_val(div_load),
    .pulse(div_pulse), .half(div_half)
  );

  tc_divider #(.CW(REF_W)) u_ref (
    .clk(clk), .rst_n(rst_n), .tick(xtal_tick), .load_val(ref_ratio(ref_sel)),
    .pulse(ref_pulse), .half(ref_half)
  );

  tpll_pfd u_pfd (
    .clk(clk), .rst_n(rst_n), .ref_ev(ref_pulse), .div_ev(div_pulse),
    .up(pd_up), .dn(pd_dn), .clr_evt(cmp_done)
  );

  tpll_lockdet #(.WIN_CYC(WIN_CYC), .LOCK_CNT(LOCK_CNT)) u_lock (
    .clk(clk), .rst_n(rst_n), .up(pd_up), .dn(pd_dn), .cmp_done(cmp_done),
    .lock(lock), .wide_err(wide_err)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) test_out <= 1'b0;
    else        test_out <= test_en && (test_sel ? div_half : ref_half);
  end

endmodule

// File: rtl/tpll_chk.sv
module tpll_chk (
  input logic clk,
  input logic rst_n,
  input logic pd_up,
  input logic pd_dn,
  input logic lock,
  input logic test_en,
  input logic test_out,
  input logic ref_pulse,
  input logic div_pulse,
  input logic cmp_done,
  input logic wide_err
);

  p_div_gap_r1: assert property (@(posedge clk) disable iff (!rst_n)
    div_pulse |=> !div_pulse);

  p_ref_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ref_pulse |=> !ref_pulse);

  p_up_src_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pd_up) |-> $past(ref_pulse));

  p_dn_src_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pd_dn) |-> $past(div_pulse));

  p_one_overlap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (pd_up && pd_dn) |=> !(pd_up || pd_dn));

  p_lock_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lock) |-> $past(cmp_done));

  p_lock_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wide_err |=> !lock);

  p_test_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !test_en |=> !test_out);

endmodule

bind tpll_core tpll_chk u_chk (
  .clk(clk), .rst_n(rst_n), .pd_up(pd_up), .pd_dn(pd_dn), .lock(lock),
  .test_en(test_en), .test_out(test_out), .ref_pulse(ref_pulse),
  .div_pulse(div_pulse), .cmp_done(cmp_done), .wide_err(wide_err)
);

// File: tb/sim_tpll_core.sv
module sim_tpll_core;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic vco_tick = 1'b0, xtal_tick = 1'b0;
  logic [14:0] div_word = 15'd64;
  logic [1:0] ref_sel = 2'b00;
  logic test_en = 1'b0, test_sel = 1'b0;
  logic pd_up, pd_dn, lock, test_out;

  int checks = 0, fails = 0;
  int both_run = 0;
  bit prev_both = 1'b0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  tpll_core u0 (
    .clk(clk), .rst_n(rst_n), .vco_tick(vco_tick), .xtal_tick(xtal_tick),
    .div_word(div_word), .ref_sel(ref_sel), .test_en(test_en),
    .test_sel(test_sel), .pd_up(pd_up), .pd_dn(pd_dn), .lock(lock),
    .test_out(test_out)
  );

  // R5 monitor: both steering outputs high on two samples in a row.
  always @(negedge clk) begin
    if (rst_n && pd_up && pd_dn && prev_both) both_run++;
    prev_both = rst_n && pd_up && pd_dn;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; vco_tick = 1'b0; xtal_tick = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  // Wait for the next toggle of test_out.
  task automatic sync_toggle();
    logic p;
    p = test_out;
    do @(negedge clk); while (test_out == p);
  endtask

  // Clocks from the current toggle to the next one.
  task automatic span(output int n);
    logic p;
    p = test_out;
    n = 0;
    do begin @(negedge clk); n++; end while (test_out == p);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    check(!pd_up && !pd_dn && !lock && !test_out, "R10 during reset",
          {pd_up, pd_dn, lock, test_out}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!pd_up && !pd_dn && !lock && !test_out, "R10 after reset",
          {pd_up, pd_dn, lock, test_out}, 0);
  endtask

  task automatic t_ref_ratio();
    int n;
    test_en = 1'b1; test_sel = 1'b0; ref_sel = 2'b00;
    do_reset(); xtal_tick = 1'b1;
    sync_toggle(); span(n); check(n == 64, "R3 code 00", n, 64);
    check(n == 64, "R8 reference half rate", n, 64);
    sync_toggle(); ref_sel = 2'b01;
    span(n); check(n == 64, "R3 old ratio kept", n, 64);
    span(n); check(n == 80, "R3 code 01", n, 80);
    sync_toggle(); ref_sel = 2'b10; span(n); span(n);
    check(n == 128, "R3 code 10", n, 128);
    sync_toggle(); ref_sel = 2'b11; span(n); span(n);
    check(n == 128, "R3 reserved code 11", n, 128);
  endtask

  task automatic t_main_div();
    int n;
    test_en = 1'b1; test_sel = 1'b1; div_word = 15'd100;
    do_reset(); vco_tick = 1'b1;
    sync_toggle(); span(n); check(n == 100, "R1 word 100", n, 100);
    check(n == 100, "R8 divider half rate", n, 100);
    sync_toggle(); div_word = 15'd37;
    span(n); check(n == 100, "R2 old word kept", n, 100);
    span(n); check(n == 37, "R2 new word applied", n, 37);
    div_word = 15'd0; sync_toggle(); span(n); span(n);
    check(n == 2, "R1 word 0 acts as 2", n, 2);
    div_word = 15'd1; sync_toggle(); span(n); span(n);
    check(n == 2, "R1 word 1 acts as 2", n, 2);
  endtask

  task automatic t_test_off();
    int seen = 0;
    test_en = 1'b0; div_word = 15'd3;
    do_reset(); vco_tick = 1'b1; xtal_tick = 1'b1;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (test_out) seen++;
    end
    check(seen == 0, "R9 test output quiet", seen, 0);
  endtask

  // Fixed phase offset of k clocks between reference and divider.
  task automatic t_lock_offset(input int k, input bit exp_lock);
    test_en = 1'b0; ref_sel = 2'b00; div_word = 15'd64;
    do_reset(); xtal_tick = 1'b1;
    repeat (k) @(negedge clk);
    vco_tick = 1'b1;
    repeat (5 * 64) @(negedge clk);
    check(lock == 1'b0, "R6 no lock before eight comparisons", lock, 0);
    repeat (8 * 64) @(negedge clk);
    if (exp_lock) check(lock == 1'b1, "R6 lock with narrow error", lock, 1);
    else          check(lock == 1'b0, "R7 wide error never locks", lock, 0);
  endtask

  task automatic t_lock_loss();
    t_lock_offset(0, 1'b1);
    div_word = 15'd65;
    repeat (10 * 64) @(negedge clk);
    check(lock == 1'b0, "R7 lock lost on drift", lock, 0);
  endtask

  task automatic t_direction(input logic [14:0] w, input bit ref_leads);
    int up_alone = 0, dn_alone = 0;
    test_en = 1'b0; ref_sel = 2'b00; div_word = w;
    do_reset(); xtal_tick = 1'b1; vco_tick = 1'b1;
    for (int i = 0; i < 20 * 64; i++) begin
      @(negedge clk);
      if (pd_up && !pd_dn) up_alone++;
      if (pd_dn && !pd_up) dn_alone++;
    end
    if (ref_leads) begin
      check(up_alone > 0, "R4 up when reference leads", up_alone, 1);
      check(dn_alone == 0, "R4 no down when reference leads", dn_alone, 0);
    end else begin
      check(dn_alone > 0, "R4 down when divider leads", dn_alone, 1);
      check(up_alone == 0, "R4 no up when divider leads", up_alone, 0);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_ref_ratio();
    t_main_div();
    t_test_off();
    t_lock_offset(0, 1'b1);
    t_lock_offset(3, 1'b1);
    t_lock_offset(4, 1'b0);
    t_lock_loss();
    t_direction(15'd65, 1'b1);
    t_direction(15'd63, 1'b0);
    check(both_run == 0, "R5 overlap lasts one clock", both_run, 0);
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule